// File: doc/BRIEF.md
# Queue Transfer Result Update Unit

This block sits behind the transaction engine of a USB host that serves queue-managed endpoints (control, bulk and interrupt). It accepts the outcome of one bus transaction together with the current descriptor overlay fields. From these it computes the new overlay: the Active and Halted bits, the 2-bit error counter, the data toggle, the bytes remaining, the page index and the byte offset. It also decides whether that overlay must be stored back to memory, and it flags short packets.

Results enter on a valid/ready channel and leave on a second valid/ready channel held in a single output register. `res_ready` is high whenever the output register is empty or is being drained in the same cycle (`upd_ready` high). A result is accepted on a rising edge where `res_valid` and `res_ready` are both high. The update it produces appears on the following cycle with `upd_valid` high. The update stays stable until it is taken on an edge with `upd_ready` high.

Every halt sets a sticky error status bit. Software clears it by writing one. With the interrupt enable set, a pending error raises the interrupt request at the next interrupt threshold tick.

Top module: `qwb_result_update`

## Requirements
- R1: An accepted result (`res_valid` and `res_ready` high on a rising edge) produces `upd_valid` high one cycle later with all update fields. `res_ready` equals `!upd_valid || upd_ready`. After reset, `upd_valid`, `err_sts` and `irq` are 0.
- R2: The handshake code `res_hs` is 0 = ACK, 1 = NAK, 2 = STALL, 3 = transaction error. `upd_wb` is 1 for every result except a NAK with `nak_reload` equal to 0.
- R3: A STALL, a babble, or a transaction error that leaves the error counter at 0 halts the queue: `upd_halted` = 1 and `upd_active` = 0. Any other result gives `upd_halted` = 0.
- R4: On a halt, the bytes remaining, page, offset and toggle equal their input values. The error counter still follows R5.
- R5: A transaction error decrements the counter, which saturates at 0. A successful ACK reloads it to 3. NAK, STALL and babble leave it unchanged.
- R6: `res_dir_in` = 1 marks an IN. An ACKed IN with `res_rx_cnt` greater than min(`max_pkt`, `cur_bytes`) is a babble.
- R7: A successful IN that moves fewer than `max_pkt` bytes sets `upd_short` and clears `upd_active`.
- R8: A successful ACK flips the toggle. It moves `res_rx_cnt` bytes for an IN, and min(`max_pkt`, `cur_bytes`) for an OUT. Bytes remaining drop by the moved count. The offset advances modulo 4096, and the page increments (modulo 2^PAGE_W) when the offset crosses 4096.
- R9: A successful ACK that leaves 0 bytes remaining clears `upd_active`. A NAK, or an error that does not halt, leaves `upd_active` at 1 with no progress.
- R10: `err_sts` sets on the cycle after a halting result is accepted. It clears on the cycle after `err_clr` is 1. A set and a clear in the same cycle leave it set.
- R11: `irq` rises only on the cycle after a `thresh_tick` on which `err_sts` was already 1 and `err_int_en` was 1. It falls when `err_sts` clears or the enable is 0.
- R12: `upd_split` is 1 when `hs_ep` is 0. It tells the writer to include the split-transaction fields.
- R13: While `upd_valid` is 1 and `upd_ready` is 0, all update outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result accepted this edge |
| res_dir_in | input | 1 | 1 = IN, 0 = OUT |
| res_hs | input | 2 | Handshake code (R2) |
| res_rx_cnt | input | BW | Bytes received on an IN |
| cur_toggle | input | 1 | Current data toggle |
| cur_cerr | input | 2 | Current error counter |
| cur_bytes | input | BW | Current bytes remaining |
| cur_page | input | PW | Current page index |
| cur_offset | input | OW | Current byte offset |
| max_pkt | input | MW | Maximum packet length |
| nak_reload | input | RW | NAK reload count |
| hs_ep | input | 1 | 1 = high-speed endpoint |
| upd_valid | output | 1 | Update available |
| upd_ready | input | 1 | Update taken |
| upd_wb | output | 1 | Write overlay back |
| upd_active | output | 1 | New Active bit |
| upd_halted | output | 1 | New Halted bit |
| upd_cerr | output | 2 | New error counter |
| upd_toggle | output | 1 | New data toggle |
| upd_bytes | output | BW | New bytes remaining |
| upd_page | output | PW | New page index |
| upd_offset | output | OW | New byte offset |
| upd_short | output | 1 | Short packet seen |
| upd_split | output | 1 | Include split-transaction fields |
| err_int_en | input | 1 | Error interrupt enable |
| thresh_tick | input | 1 | Interrupt threshold tick |
| err_clr | input | 1 | Write-one-to-clear for error status |
| err_sts | output | 1 | Sticky error status |
| irq | output | 1 | Interrupt request |

## Verification
Two events can meet on one edge: the accept of a halting result and a write-one-to-clear of the sticky error status. The bench provokes this by sending a STALL while holding `err_clr` high. It then expects `err_sts` to be set on the next cycle. A second collision pairs the halting accept with `thresh_tick`. Because the status was not yet set at that tick, `irq` must stay low until a later tick.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_XERR  = 2'd3
  } hs_e;

  typedef struct packed {
    logic halt;
    logic progress;
    logic short_pkt;
    logic babble;
    logic wb;
  } cls_t;

  localparam logic [1:0] CERR_FULL = 2'd3;
endpackage

// File: rtl/qwb_classify.sv
module qwb_classify
  import qwb_pkg::*;
#(
  parameter int BW = 15,
  parameter int MW = 11,
  parameter int RW = 4
) (
  input  logic          dir_in,
  input  logic [1:0]    hs,
  input  logic [BW-1:0] rx_cnt,
  input  logic [BW-1:0] bytes,
  input  logic [MW-1:0] max_pkt,
  input  logic [1:0]    cerr,
  input  logic [RW-1:0] nak_reload,
  output cls_t          cls,
  output logic [BW-1:0] moved,
  output logic [1:0]    cerr_n
);
  logic [BW-1:0] mpl_ext, lim;
  logic ack, nak, stall, xerr;

  always_comb begin
    mpl_ext = BW'(max_pkt);
    lim     = (mpl_ext < bytes) ? mpl_ext : bytes;
    ack     = (hs == HS_ACK);
    nak     = (hs == HS_NAK);
    stall   = (hs == HS_STALL);
    xerr    = (hs == HS_XERR);
    moved   = dir_in ? rx_cnt : lim;
    cls.babble   = ack && dir_in && (rx_cnt > lim);
    cls.progress = ack && !cls.babble;
    cls.short_pkt = cls.progress && dir_in && (moved < mpl_ext);
    if (xerr)              cerr_n = (cerr == 2'd0) ? 2'd0 : cerr - 2'd1;
    else if (cls.progress) cerr_n = CERR_FULL;
    else                   cerr_n = cerr;
    cls.halt = stall || cls.babble || (xerr && (cerr_n == 2'd0));
    cls.wb   = !(nak && (nak_reload == '0));
  end

  always_comb begin
    a_r6_babble_halts: assert (!cls.babble || cls.halt);
    a_r3_halt_not_progress: assert (!(cls.halt && cls.progress));
  end
endmodule

// File: rtl/qwb_progress.sv
module qwb_progress #(
  parameter int BW = 15,
  parameter int OW = 12,
  parameter int PW = 3
) (
  input  logic          go,
  input  logic [BW-1:0] moved,
  input  logic [BW-1:0] bytes,
  input  logic [PW-1:0] page,
  input  logic [OW-1:0] offset,
  input  logic          toggle,
  output logic [BW-1:0] bytes_n,
  output logic [PW-1:0] page_n,
  output logic [OW-1:0] offset_n,
  output logic          toggle_n,
  output logic          done
);
  logic [BW:0] sum;

  always_comb begin
    sum = (BW+1)'(offset) + (BW+1)'(moved);
    if (go) begin
      bytes_n  = bytes - moved;
      offset_n = OW'(sum);
      page_n   = page + PW'(sum >> OW);
      toggle_n = !toggle;
    end else begin
      bytes_n  = bytes;
      offset_n = offset;
      page_n   = page;
      toggle_n = toggle;
    end
    done = go && (bytes_n == '0);
  end

  always_comb begin
    a_r4_frozen_when_idle: assert (go || (bytes_n == bytes && offset_n == offset));
  end
endmodule

// File: rtl/qwb_status.sv
module qwb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic sts,
  output logic irq
);
  logic sts_n;

  always_comb sts_n = set || (sts && !clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= 1'b0;
      irq <= 1'b0;
    end else begin
      sts <= sts_n;
      irq <= en && sts_n && (irq || (tick && sts));
    end
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> sts);
  a_r11_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts);
  a_r11_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
endmodule

// File: rtl/qwb_result_update.sv
module qwb_result_update
  import qwb_pkg::*;
#(
  parameter int BW = 15,
  parameter int MW = 11,
  parameter int OW = 12,
  parameter int PW = 3,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic          res_dir_in,
  input  logic [1:0]    res_hs,
  input  logic [BW-1:0] res_rx_cnt,
  input  logic          cur_toggle,
  input  logic [1:0]    cur_cerr,
  input  logic [BW-1:0] cur_bytes,
  input  logic [PW-1:0] cur_page,
  input  logic [OW-1:0] cur_offset,
  input  logic [MW-1:0] max_pkt,
  input  logic [RW-1:0] nak_reload,
  input  logic          hs_ep,
  output logic          upd_valid,
  input  logic          upd_ready,
  output logic          upd_wb,
  output logic          upd_active,
  output logic          upd_halted,
  output logic [1:0]    upd_cerr,
  output logic          upd_toggle,
  output logic [BW-1:0] upd_bytes,
  output logic [PW-1:0] upd_page,
  output logic [OW-1:0] upd_offset,
  output logic          upd_short,
  output logic          upd_split,
  input  logic          err_int_en,
  input  logic          thresh_tick,
  input  logic          err_clr,
  output logic          err_sts,
  output logic          irq
);
  cls_t          cls;
  logic [BW-1:0] moved, bytes_n;
  logic [1:0]    cerr_n;
  logic [PW-1:0] page_n;
  logic [OW-1:0] offset_n;
  logic          toggle_n, done, accept;

  assign res_ready = !upd_valid || upd_ready;
  assign accept    = res_valid && res_ready;

  qwb_classify #(.BW(BW), .MW(MW), .RW(RW)) u_cls (
    .dir_in(res_dir_in), .hs(res_hs), .rx_cnt(res_rx_cnt), .bytes(cur_bytes),
    .max_pkt(max_pkt), .cerr(cur_cerr), .nak_reload(nak_reload),
    .cls(cls), .moved(moved), .cerr_n(cerr_n)
  );

  qwb_progress #(.BW(BW), .OW(OW), .PW(PW)) u_prog (
    .go(cls.progress), .moved(moved), .bytes(cur_bytes), .page(cur_page),
    .offset(cur_offset), .toggle(cur_toggle), .bytes_n(bytes_n),
    .page_n(page_n), .offset_n(offset_n), .toggle_n(toggle_n), .done(done)
  );

  qwb_status u_sts (
    .clk(clk), .rst_n(rst_n), .set(accept && cls.halt), .clr(err_clr),
    .en(err_int_en), .tick(thresh_tick), .sts(err_sts), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
    end else begin
      upd_valid <= accept || (upd_valid && !upd_ready);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      upd_wb     <= cls.wb;
      upd_halted <= cls.halt;
      upd_active <= !cls.halt && !cls.short_pkt && !done;
      upd_cerr   <= cerr_n;
      upd_toggle <= toggle_n;
      upd_bytes  <= bytes_n;
      upd_page   <= page_n;
      upd_offset <= offset_n;
      upd_short  <= cls.short_pkt;
      upd_split  <= !hs_ep;
    end
  end

  a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> upd_valid);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ready) |=> (upd_valid && $stable(upd_bytes) && $stable(upd_offset)
                                   && $stable(upd_halted) && $stable(upd_wb)));
  a_r3_halt_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_halted) |-> !upd_active);
  a_r4_halt_keeps_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && res_hs == HS_STALL) |=> (upd_bytes == $past(cur_bytes)
                                        && upd_toggle == $past(cur_toggle)));
  a_r10_halt_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && res_hs == HS_STALL) |=> err_sts);
endmodule

// File: tb/sim_qwb_result_update.sv
module sim_qwb_result_update;
  localparam int BW = 15, MW = 11, OW = 12, PW = 3, RW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 0, res_ready, res_dir_in = 0;
  logic [1:0] res_hs = 0;
  logic [BW-1:0] res_rx_cnt = 0, cur_bytes = 0;
  logic cur_toggle = 0;
  logic [1:0] cur_cerr = 0;
  logic [PW-1:0] cur_page = 0;
  logic [OW-1:0] cur_offset = 0;
  logic [MW-1:0] max_pkt = 8;
  logic [RW-1:0] nak_reload = 0;
  logic hs_ep = 0, upd_valid, upd_ready = 1;
  logic upd_wb, upd_active, upd_halted, upd_toggle, upd_short, upd_split;
  logic [1:0] upd_cerr;
  logic [BW-1:0] upd_bytes;
  logic [PW-1:0] upd_page;
  logic [OW-1:0] upd_offset;
  logic err_int_en = 0, thresh_tick = 0, err_clr = 0, err_sts, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = !clk;

  qwb_result_update #(.BW(BW), .MW(MW), .OW(OW), .PW(PW), .RW(RW)) u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_one();
    res_valid = 1;
    @(negedge clk);
    res_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rxs[5] = '{0, 3, 7, 8, 9};
    int bys[4] = '{0, 5, 8, 20};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset upd_valid", upd_valid, 0);
    chk("R1 reset err_sts", err_sts, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset res_ready", res_ready, 1);
    rst_n = 1;
    @(negedge clk);
    err_clr = 1;
    // sweep
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 4; h++)
        for (int c = 0; c < 4; c++)
          for (int ri = 0; ri < 5; ri++)
            for (int bi = 0; bi < 4; bi++)
              for (int o = 0; o < 2; o++) begin
                int lim, mv, cn, sum, eb, ep, eo, et, ea, eh, es;
                bit ack, bab, prog, halt;
                res_dir_in = d[0]; res_hs = h[1:0]; cur_cerr = c[1:0];
                res_rx_cnt = BW'(rxs[ri]); cur_bytes = BW'(bys[bi]);
                cur_offset = o ? OW'(4094) : OW'(0);
                cur_page = o ? PW'(7) : PW'(2);
                cur_toggle = c[0]; hs_ep = o[0];
                nak_reload = bi[0] ? RW'(0) : RW'(2);
                lim = (bys[bi] < 8) ? bys[bi] : 8;
                mv = d ? rxs[ri] : lim;
                ack = (h == 0);
                bab = ack && d == 1 && rxs[ri] > lim;
                prog = ack && !bab;
                if (h == 3) cn = (c == 0) ? 0 : c - 1;
                else if (prog) cn = 3;
                else cn = c;
                halt = (h == 2) || bab || (h == 3 && cn == 0);
                es = (prog && d == 1 && mv < 8) ? 1 : 0;
                if (prog) begin
                  sum = (o ? 4094 : 0) + mv;
                  eb = bys[bi] - mv; eo = sum % 4096;
                  ep = ((o ? 7 : 2) + sum / 4096) % 8; et = 1 - (c % 2);
                end else begin
                  eb = bys[bi]; eo = o ? 4094 : 0; ep = o ? 7 : 2; et = c % 2;
                end
                ea = (!halt && !es && !(prog && eb == 0)) ? 1 : 0;
                eh = halt ? 1 : 0;
                send_one();
                chk("R1 upd_valid", upd_valid, 1);
                chk("R2 upd_wb", upd_wb, (h == 1 && bi % 2 == 1) ? 0 : 1);
                chk("R3 R6 upd_halted", upd_halted, eh);
                chk("R9 upd_active", upd_active, ea);
                chk("R5 upd_cerr", upd_cerr, cn);
                chk("R4 R8 upd_bytes", upd_bytes, eb);
                chk("R4 R8 upd_offset", upd_offset, eo);
                chk("R4 R8 upd_page", upd_page, ep);
                chk("R8 upd_toggle", upd_toggle, et);
                chk("R7 upd_short", upd_short, es);
                chk("R12 upd_split", upd_split, o ? 0 : 1);
              end
    @(negedge clk);
    chk("R10 cleared by w1c", err_sts, 0);
    // R13: back-pressure
    upd_ready = 0;
    res_dir_in = 0; res_hs = 2'd0; cur_bytes = 20; cur_offset = 0; cur_page = 0;
    cur_toggle = 0; cur_cerr = 1;
    send_one();
    chk("R13 first valid", upd_valid, 1);
    chk("R13 first bytes", upd_bytes, 12);
    chk("R1 ready low when full", res_ready, 0);
    cur_bytes = 5; res_valid = 1;
    @(negedge clk);
    chk("R13 held bytes", upd_bytes, 12);
    chk("R13 still valid", upd_valid, 1);
    upd_ready = 1;
    @(negedge clk);
    res_valid = 0;
    chk("R13 second bytes", upd_bytes, 0);
    chk("R9 done clears active", upd_active, 0);
    @(negedge clk);
    chk("R1 drained", upd_valid, 0);
    // R10: set and clear in same cycle, R11: tick with halt same cycle
    err_clr = 1; err_int_en = 1; thresh_tick = 1;
    res_hs = 2'd2; cur_bytes = 20;
    send_one();
    err_clr = 0;
    chk("R10 set wins over clear", err_sts, 1);
    chk("R11 no irq on same-cycle tick", irq, 0);
    thresh_tick = 0;
    @(negedge clk);
    chk("R11 irq waits for tick", irq, 0);
    thresh_tick = 1;
    @(negedge clk);
    thresh_tick = 0;
    chk("R11 irq after tick", irq, 1);
    @(negedge clk);
    chk("R11 irq stays", irq, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk("R10 w1c clears", err_sts, 0);
    chk("R11 irq drops with status", irq, 0);
    // R11: enable low blocks irq
    err_int_en = 0; res_hs = 2'd2;
    send_one();
    thresh_tick = 1;
    @(negedge clk);
    thresh_tick = 0;
    chk("R11 disabled no irq", irq, 0);
    chk("R10 status still set", err_sts, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule